// File: doc/BRIEF.md
# Burst Write-Readback Memory Tester

This block is a small master-side sequencer that sits on a wide, burst-capable memory-mapped port, such as the port in front of an external memory controller. It checks that a short burst written to memory comes back intact. After reset it stays idle until the controller reports that calibration has succeeded. It then writes one burst of four full-width words at a fixed start address. After a short quiet gap it issues one read burst of the same length from the same address. It places each returned beat in its own capture register.

The slave's flow-control input is an active-low wait. A high level on that input means "accepted on this edge", so the port treats it as a ready signal. Read beats are counted one per valid strobe, and idle cycles between strobes are allowed. A strobe that arrives when no beat is expected sets a sticky protocol-error flag and is not captured again. This covers a strobe held high for many cycles and a strobe that arrives before the read command has been taken.

When the fourth beat has been captured, the block raises done. It also reports pass or fail, based on a comparison against the written pattern. A cycle counter runs from the first command cycle until done. If done is not reached within a fixed limit, the sequence stops and fail is raised.

Top module: `burst_rw_checker`

## Requirements
- R1: No write or read strobe is driven before `cal_ok` has been seen high. After reset, with `cal_ok` low, both strobes stay at 0 and every status output is 0.
- R2: The write burst carries burst count 4 at word address 0. Its four beats hold the values 4, 1, 2, 3 in that order, each zero-extended to the 576-bit word.
- R3: Every one of the 72 byte-enables (one per 8-bit lane) is 1 on every write beat.
- R4: A write beat is taken only on an edge where `mm_wait_n` is 1. While `mm_wait_n` is 0, the write strobe, address, burst count and data are held unchanged.
- R5: The read command is issued only after all four write beats have been taken. It is a single accepted cycle carrying address 0 and burst count 4, and the read strobe drops in the cycle after acceptance.
- R6: Each `mm_rvalid` strobe during the read phase captures one beat. Idle cycles between strobes are allowed. Beat k goes to capture slot k, and slot k sits at bits [k*576 +: 576] of `rd_beats`.
- R7: `done` rises once the fourth beat has been captured. After that, the capture slots do not change.
- R8: `pass` is 1 when done is set, all four slots equal the written pattern in order, and no protocol error has occurred.
- R9: A valid strobe outside the read window sets `proto_err` and is not captured. The read window opens when the read command is accepted and closes once four beats are held. `proto_err` stays set until reset, and it forces `fail`.
- R10: If done is reached with any slot differing from the written pattern, including a stale repeat of the first beat, `fail` is 1 and `pass` is 0.
- R11: `elapsed` counts the cycles from leaving the idle state until done. It then holds its value.
- R12: If done has not been reached after TIMEOUT_CYC (default 1024) counted cycles, `fail` rises, `elapsed` holds at TIMEOUT_CYC, both strobes drop, and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_ok | input | 1 | Controller out of reset and calibrated |
| mm_wait_n | input | 1 | Active-low wait from the slave; 1 means the current command or beat is taken |
| mm_addr | output | ADDR_W (26) | Word address |
| mm_bcount | output | BCNT_W (3) | Burst count |
| mm_wr | output | 1 | Write strobe |
| mm_rd | output | 1 | Read strobe |
| mm_wdata | output | DATA_W (576) | Write data |
| mm_be | output | DATA_W/LANE_W (72) | Byte-enables, one per lane |
| mm_rdata | input | DATA_W (576) | Read data |
| mm_rvalid | input | 1 | Read data valid strobe |
| rd_beats | output | BURST_LEN*DATA_W (2304) | Capture slots, slot k at [k*DATA_W +: DATA_W] |
| elapsed | output | clog2(TIMEOUT_CYC+1) (11) | Cycle count from start to done |
| done | output | 1 | All beats captured |
| pass | output | 1 | Readback matched, no protocol error |
| fail | output | 1 | Mismatch, protocol error or timeout |
| proto_err | output | 1 | Sticky stray-strobe flag |

## Verification
The bench runs several seeded random runs. Each run uses a random calibration delay, random wait back-pressure and a random gap probability between read strobes. These runs show that beats advance only on acceptance and that capture follows strobes rather than clock cycles. A fault-injection group follows:
- A single flipped high bit in one returned beat shows that the comparison covers the full zero-extended word.
- A responder that returns the first word for every strobe separates true per-beat capture from a stale repeat.
- A stretched valid of sixteen extra cycles after the burst, and one stray strobe during the write phase, exercise both edges of the read window.
- A silent responder exercises the timeout.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_GAP   = 3'd2,
      ST_RCMD  = 3'd3,
      ST_RWAIT = 3'd4,
      ST_DONE  = 3'd5,
      ST_HALT  = 3'd6
   } bwt_state_e;

   // Test pattern: the first beat carries the burst length, later beats their index.
   function automatic logic [31:0] beat_value(input int unsigned idx, input int unsigned len);
      return (idx == 0) ? len : idx;
   endfunction

endpackage

// File: rtl/bwt_seq.sv
module bwt_seq
   import bwt_pkg::*;
#(
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned GAP_CYC   = 2,
   localparam int unsigned BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_ok,
   input  logic              wait_n,
   input  logic              rd_all,
   input  logic              timeout,
   output bwt_state_e        state_o,
   output logic [BEAT_W-1:0] beat_o,
   output logic              wr_o,
   output logic              rd_o,
   output logic              active_o
);

   localparam int unsigned GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
   localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP_CYC - 1);

   bwt_state_e        state_q;
   logic [BEAT_W-1:0] beat_q;
   logic [GAP_W-1:0]  gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         gap_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cal_ok) state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (timeout) state_q <= ST_HALT;
               else if (wait_n) begin
                  if (beat_q == LAST_BEAT) state_q <= ST_GAP;
                  else                     beat_q  <= beat_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (timeout)                state_q <= ST_HALT;
               else if (gap_q == LAST_GAP) state_q <= ST_RCMD;
               else                        gap_q   <= gap_q + 1'b1;
            end
            ST_RCMD: begin
               if (timeout)     state_q <= ST_HALT;
               else if (wait_n) state_q <= ST_RWAIT;
            end
            ST_RWAIT: begin
               if (timeout)     state_q <= ST_HALT;
               else if (rd_all) state_q <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign state_o  = state_q;
   assign beat_o   = beat_q;
   assign wr_o     = (state_q == ST_WRITE);
   assign rd_o     = (state_q == ST_RCMD);
   assign active_o = (state_q == ST_WRITE) || (state_q == ST_GAP) ||
                     (state_q == ST_RCMD)  || (state_q == ST_RWAIT);

   AST_DONE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RWAIT) && !rd_all |=> state_q != ST_DONE); // R7

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> (state_q == ST_HALT) && !wr_o && !rd_o); // R12

endmodule

// File: rtl/bwt_capture.sv
module bwt_capture
   import bwt_pkg::*;
#(
   parameter int unsigned DATA_W    = 576,
   parameter int unsigned BURST_LEN = 4,
   parameter bit          IN_REG    = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          arm,
   input  logic                          rvalid,
   input  logic [DATA_W-1:0]             rdata,
   output logic [BURST_LEN*DATA_W-1:0]   cap_flat,
   output logic                          all_in,
   output logic                          stray,
   output logic                          match
);

   localparam int unsigned CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BURST_LEN);

   logic              v_s;
   logic [DATA_W-1:0] d_s;

   generate
      if (IN_REG) begin : g_inreg
         logic              v_q;
         logic [DATA_W-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= rvalid;
               d_q <= rdata;
            end
         end
         assign v_s = v_q;
         assign d_s = d_q;
      end else begin : g_direct
         assign v_s = rvalid;
         assign d_s = rdata;
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             stray_q;
   logic             take;

   assign take = v_s && arm && (cnt_q != FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stray_q <= 1'b0;
      end else begin
         if (take)            cnt_q   <= cnt_q + 1'b1;
         if (v_s && !take)    stray_q <= 1'b1;
      end
   end

   logic [BURST_LEN-1:0] hit;

   generate
      for (genvar g = 0; g < BURST_LEN; g++) begin : g_slot
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot_q <= '0;
            else if (take && (cnt_q == CNT_W'(g)))   slot_q <= d_s;
         end
         assign cap_flat[g*DATA_W +: DATA_W] = slot_q;
         assign hit[g] = (slot_q == DATA_W'(beat_value(g, BURST_LEN)));
      end
   endgenerate

   assign all_in = (cnt_q == FULL);
   assign stray  = stray_q;
   assign match  = &hit;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL); // R6

   AST_SLOTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      all_in |=> $stable(cap_flat)); // R7

   AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      v_s && !(arm && cnt_q != FULL) |=> stray_q); // R9

   AST_STRAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stray_q |=> stray_q); // R9

endmodule

// File: rtl/bwt_timer.sv
module bwt_timer #(
   parameter int unsigned TIMEOUT_CYC = 1024,
   localparam int unsigned T_W        = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           running,
   output logic [T_W-1:0] elapsed,
   output logic           timeout
);

   localparam logic [T_W-1:0] LAST = T_W'(TIMEOUT_CYC - 1);

   logic [T_W-1:0] el_q;
   logic           to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         el_q <= '0;
         to_q <= 1'b0;
      end else if (running && !to_q) begin
         el_q <= el_q + 1'b1;
         if (el_q == LAST) to_q <= 1'b1;
      end
   end

   assign elapsed = el_q;
   assign timeout = to_q;

   AST_ELAPSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> $stable(el_q)); // R11

   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      to_q |=> to_q && $stable(el_q)); // R12

endmodule

// File: rtl/burst_rw_checker.sv
module burst_rw_checker
   import bwt_pkg::*;
#(
   parameter int unsigned DATA_W      = 576,
   parameter int unsigned LANE_W      = 8,
   parameter int unsigned ADDR_W      = 26,
   parameter int unsigned BCNT_W      = 3,
   parameter int unsigned BURST_LEN   = 4,
   parameter int unsigned GAP_CYC     = 2,
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter bit          IN_REG      = 1'b0,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   localparam int unsigned LANES      = DATA_W / LANE_W,
   localparam int unsigned EL_W       = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cal_ok,
   input  logic                        mm_wait_n,
   output logic [ADDR_W-1:0]           mm_addr,
   output logic [BCNT_W-1:0]           mm_bcount,
   output logic                        mm_wr,
   output logic                        mm_rd,
   output logic [DATA_W-1:0]           mm_wdata,
   output logic [LANES-1:0]            mm_be,
   input  logic [DATA_W-1:0]           mm_rdata,
   input  logic                        mm_rvalid,
   output logic [BURST_LEN*DATA_W-1:0] rd_beats,
   output logic [EL_W-1:0]             elapsed,
   output logic                        done,
   output logic                        pass,
   output logic                        fail,
   output logic                        proto_err
);

   localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   generate
      if (LANE_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
         $error("DATA_W must be a whole number of lanes");
      end
      if (BURST_LEN < 1 || BURST_LEN >= (1 << BCNT_W)) begin : g_bad_len
         $error("BURST_LEN must be at least 1 and fit in BCNT_W");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (TIMEOUT_CYC < 2 * BURST_LEN + GAP_CYC + 2) begin : g_bad_to
         $error("TIMEOUT_CYC too small for one write and one read burst");
      end
   endgenerate

   bwt_state_e        state;
   logic [BEAT_W-1:0] wbeat;
   logic              wr_s, rd_s, active, timeout, all_in, stray, match;

   bwt_seq #(.BURST_LEN(BURST_LEN), .GAP_CYC(GAP_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_ok   (cal_ok),
      .wait_n   (mm_wait_n),
      .rd_all   (all_in),
      .timeout  (timeout),
      .state_o  (state),
      .beat_o   (wbeat),
      .wr_o     (wr_s),
      .rd_o     (rd_s),
      .active_o (active)
   );

   bwt_capture #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .IN_REG(IN_REG)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (state == ST_RWAIT),
      .rvalid   (mm_rvalid),
      .rdata    (mm_rdata),
      .cap_flat (rd_beats),
      .all_in   (all_in),
      .stray    (stray),
      .match    (match)
   );

   bwt_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (active),
      .elapsed (elapsed),
      .timeout (timeout)
   );

   assign mm_wr     = wr_s;
   assign mm_rd     = rd_s;
   assign mm_addr   = (wr_s || rd_s) ? START_ADDR : '0;
   assign mm_bcount = (wr_s || rd_s) ? BCNT_W'(BURST_LEN) : '0;
   assign mm_wdata  = wr_s ? DATA_W'(beat_value(32'(wbeat), BURST_LEN)) : '0;
   assign mm_be     = wr_s ? '1 : '0;

   assign done      = (state == ST_DONE);
   assign proto_err = stray;
   assign pass      = done && match && !stray;
   assign fail      = timeout || (done && !(match && !stray));

   AST_NO_CMD_PRECAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mm_wr) |-> $past(cal_ok)); // R1

   AST_WBEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mm_wr && !mm_wait_n |=> mm_wr && $stable(mm_wdata) && $stable(mm_addr) && $stable(mm_bcount)); // R4

   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mm_rd && mm_wait_n |=> !mm_rd); // R5

   AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail)); // R8

endmodule

// File: tb/tb_burst_rw_checker.sv
module tb_burst_rw_checker;

   localparam int DW = 576;
   localparam int NB = 4;
   localparam int TO = 1024;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cal_ok = 1'b0;
   logic           mm_wait_n;
   logic [25:0]    mm_addr;
   logic [2:0]     mm_bcount;
   logic           mm_wr, mm_rd;
   logic [DW-1:0]  mm_wdata;
   logic [71:0]    mm_be;
   logic [DW-1:0]  mm_rdata;
   logic           mm_rvalid;
   logic [NB*DW-1:0] rd_beats;
   logic [10:0]    elapsed;
   logic           done, pass, fail, proto_err;

   always #5 clk = ~clk;

   burst_rw_checker dut (
      .clk(clk), .rst_n(rst_n), .cal_ok(cal_ok), .mm_wait_n(mm_wait_n),
      .mm_addr(mm_addr), .mm_bcount(mm_bcount), .mm_wr(mm_wr), .mm_rd(mm_rd),
      .mm_wdata(mm_wdata), .mm_be(mm_be), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
      .rd_beats(rd_beats), .elapsed(elapsed), .done(done), .pass(pass),
      .fail(fail), .proto_err(proto_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Responder modes
   bit m_wait_rand = 1'b0;
   int m_gap       = 0;
   int m_extra     = 0;
   int m_corrupt   = 0;   // 0 none, 1 flip bit in one beat, 2 stale first word
   int m_cidx      = 0;
   bit m_early     = 1'b0;
   bit m_no_resp   = 1'b0;

   // Responder state and monitors
   logic [DW-1:0] mem [NB];
   int  wcnt, rd_pend, rd_idx, extra_left;
   int  early_cmd, rd_early, attr_err, hold_err, n_rcmd;
   bit  stray_done, stall_q;
   logic [DW-1:0] wdata_q;

   function automatic logic [DW-1:0] exp_beat(input int k);
      case (k)
         0: return DW'(4);
         1: return DW'(1);
         2: return DW'(2);
         default: return DW'(3);
      endcase
   endfunction

   function automatic logic [DW-1:0] resp_data(input int k);
      logic [DW-1:0] d;
      d = mem[k];
      if (m_corrupt == 1 && k == m_cidx) d[500] = ~d[500];
      if (m_corrupt == 2) d = mem[0];
      return d;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) mem[i] <= {18{32'hDEAD_BEEF}};
         wcnt <= 0; rd_pend <= 0; rd_idx <= 0; extra_left <= 0;
         early_cmd <= 0; rd_early <= 0; attr_err <= 0; hold_err <= 0; n_rcmd <= 0;
         stray_done <= 1'b0; stall_q <= 1'b0; wdata_q <= '0;
         mm_wait_n <= 1'b1; mm_rvalid <= 1'b0; mm_rdata <= '0;
      end else begin
         mm_wait_n <= m_wait_rand ? (($urandom % 4) != 0) : 1'b1;
         if ((mm_wr || mm_rd) && !cal_ok) early_cmd <= early_cmd + 1;
         stall_q <= mm_wr && !mm_wait_n;
         wdata_q <= mm_wdata;
         if (stall_q && (!mm_wr || mm_wdata != wdata_q)) hold_err <= hold_err + 1;
         if (mm_wr && mm_wait_n) begin
            if (wcnt < NB) mem[wcnt] <= mm_wdata;
            wcnt <= wcnt + 1;
            if (mm_bcount != 3'd4 || mm_addr != '0 || mm_be != {72{1'b1}}) attr_err <= attr_err + 1;
         end
         if (mm_rd && mm_wait_n) begin
            n_rcmd <= n_rcmd + 1;
            if (wcnt != NB) rd_early <= rd_early + 1;
            if (mm_bcount != 3'd4 || mm_addr != '0) attr_err <= attr_err + 1;
            rd_pend <= NB; rd_idx <= 0; extra_left <= m_extra;
         end
         mm_rvalid <= 1'b0;
         if (m_early && mm_wr && wcnt == 1 && !stray_done) begin
            mm_rvalid <= 1'b1; mm_rdata <= '0; stray_done <= 1'b1;
         end else if (!m_no_resp && rd_pend != 0 && int'($urandom % 100) >= m_gap) begin
            mm_rvalid <= 1'b1; mm_rdata <= resp_data(rd_idx);
            rd_pend <= rd_pend - 1; rd_idx <= rd_idx + 1;
         end else if (rd_pend == 0 && extra_left != 0) begin
            mm_rvalid <= 1'b1; mm_rdata <= mem[NB-1]; extra_left <= extra_left - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin : watchdog
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
         end
      end
   end

   task automatic run(input bit wr_rand, input int gap, input int extra, input int corrupt,
                      input int cidx, input bit early, input bit noresp, input int cal_dly);
      int cnt;
      logic [10:0] el_done;
      rst_n = 1'b0; cal_ok = 1'b0;
      m_wait_rand = wr_rand; m_gap = gap; m_extra = extra; m_corrupt = corrupt;
      m_cidx = cidx; m_early = early; m_no_resp = noresp;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (cal_dly) @(negedge clk);
      chk(!mm_wr && !mm_rd, "R1", "strobe before cal_ok", {mm_wr, mm_rd}, 0);
      cal_ok = 1'b1;
      cnt = 0;
      while (!done && !fail && cnt < TO + 200) begin
         @(negedge clk); cnt++;
      end
      el_done = elapsed;
      repeat (30) @(negedge clk);
      chk(early_cmd == 0, "R1", "commands before cal_ok", early_cmd, 0);
      if (noresp) begin
         chk(fail && !done && !pass, "R12", "timeout fail/done/pass", {fail, done, pass}, 3'b100);
         chk(elapsed == 11'(TO), "R12", "elapsed held at limit", elapsed, TO);
         chk(!mm_wr && !mm_rd, "R12", "strobes after timeout", {mm_wr, mm_rd}, 0);
         return;
      end
      chk(done, "R7", "done raised", done, 1);
      for (int k = 0; k < NB; k++)
         chk(mem[k] == exp_beat(k), "R2", $sformatf("written beat %0d", k), mem[k][63:0], exp_beat(k)[63:0]);
      chk(wcnt == NB, "R2", "write beat count", wcnt, NB);
      chk(attr_err == 0, "R3", "addr/count/byte-enable errors", attr_err, 0);
      chk(hold_err == 0, "R4", "held beat changed while waiting", hold_err, 0);
      chk(n_rcmd == 1 && rd_early == 0, "R5", "read commands / early reads", {n_rcmd[15:0], rd_early[15:0]}, 32'h10000);
      chk(el_done >= 11'd9 && el_done < 11'(TO) && elapsed == el_done, "R11", "elapsed range and hold", elapsed, el_done);
      if (early || extra != 0) begin
         chk(proto_err && fail && !pass, "R9", "stray strobe flags", {proto_err, fail, pass}, 3'b110);
         for (int k = 0; k < NB; k++)
            chk(rd_beats[k*DW +: DW] == exp_beat(k), "R6", $sformatf("slot %0d after strays", k),
                rd_beats[k*DW +: 64], exp_beat(k)[63:0]);
      end else if (corrupt != 0) begin
         chk(fail && !pass && !proto_err, "R10", "mismatch flags", {fail, pass, proto_err}, 3'b100);
      end else begin
         chk(pass && !fail && !proto_err, "R8", "pass flags", {pass, fail, proto_err}, 3'b100);
         for (int k = 0; k < NB; k++)
            chk(rd_beats[k*DW +: DW] == exp_beat(k), "R6", $sformatf("slot %0d", k),
                rd_beats[k*DW +: 64], exp_beat(k)[63:0]);
         chk(rd_beats[DW +: DW] != rd_beats[0 +: DW], "R7", "slots distinct", rd_beats[DW +: 64], 1);
      end
   endtask

   initial begin
      void'($urandom(32'd7719));
      mm_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state with calibration pending
      chk(!mm_wr && !mm_rd && !done && !pass && !fail && !proto_err && elapsed == 0,
          "R1", "reset state", {mm_wr, mm_rd, done, pass, fail, proto_err}, 0);
      // directed: no back-pressure, back-to-back strobes
      run(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 20);
      // random back-pressure and gaps
      for (int i = 0; i < 6; i++)
         run(1'b1, int'($urandom % 70), 0, 0, 0, 1'b0, 1'b0, 1 + int'($urandom % 15));
      // R10: single flipped high bit, and stale first word
      run(1'b1, 30, 0, 1, int'($urandom % 4), 1'b0, 1'b0, 3);
      run(1'b0, 0, 0, 2, 0, 1'b0, 1'b0, 3);
      // R9: stretched valid after the burst, stray strobe during write
      run(1'b0, 0, 16, 0, 0, 1'b0, 1'b0, 2);
      run(1'b1, 20, 0, 0, 0, 1'b1, 1'b0, 2);
      // R12: silent responder
      run(1'b1, 0, 0, 0, 0, 1'b0, 1'b1, 2);
      summary();
      $finish;
   end

endmodule